// File: doc/BRIEF.md
# Postfix Expression Stack Evaluator

The block evaluates integer expressions written in reverse Polish (postfix) order. Tokens arrive one per accepted valid/ready handshake, strictly in the order they are sent. Each token is either an operand or a dyadic operator. An operand carries a signed value, and the block places it on an internal last-in, first-out stack. An operator takes the two newest entries, combines them, and leaves the single result in their place. The stack pointer is never visible on a port. The block does show whether the stack is empty or full, and it shows the value on top of the stack without removing it.

A separate result-request strobe removes the top entry and presents it on the result port with a one-cycle valid pulse. Misuse sets sticky error flags. An operator with too few entries, or a request on an empty stack, sets one flag. An operand pushed into a full stack sets the other. A synchronous clear empties the stack and drops both flags. Depth (8) and data width (16) are parameters.

Top module: `rpn_eval`

## Requirements
- R1: After reset, and in the cycle after `clr` is high, the stack is empty (`empty`=1, `full`=0), both error flags are 0 and `res_valid` is 0.
- R2: An accepted operand token (`tok_kind`=2'b00) pushes `tok_value`. From the next cycle `top_data` equals that value and `empty` is 0.
- R3: The stack is last-in, first-out. After operands X, Y, Z, successive result requests return Z, then Y, then X.
- R4: Operator codes on `tok_kind` are 2'b01 add, 2'b10 subtract and 2'b11 multiply. An accepted operator with at least two entries pops the top entry as the right operand and the next entry as the left operand. It pushes left op right, so the stack shrinks by one, and the result shows on `top_data` the cycle after acceptance. For example, "5 2 -" gives 3.
- R5: Results wrap modulo 2^16 in two's complement. 300*300 gives 24464, and 32767+1 gives 16'h8000.
- R6: An operator accepted while fewer than two entries are stored sets `underflow_err` and leaves the stack and `top_data` unchanged.
- R7: An operand accepted while the stack is full sets `overflow_err` and is dropped, so `top_data` keeps the previous top.
- R8: `full` is 1 exactly when DEPTH entries are stored, and `empty` is 1 exactly when none are.
- R9: A cycle with `res_req` high on a non-empty stack pops the top entry. `res_data` holds it and `res_valid` is high for exactly the next cycle. A request on an empty stack gives no pulse and sets `underflow_err`.
- R10: `tok_ready` is low whenever `clr` or `res_req` is high. A token presented then is not consumed. Priority is clear, then result request, then token.
- R11: Both error flags stay set until `clr` or reset, whatever tokens follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of stack and flags |
| tok_valid | input | 1 | Token present |
| tok_ready | output | 1 | Token can be accepted this cycle |
| tok_kind | input | 2 | 00 operand, 01 add, 10 subtract, 11 multiply |
| tok_value | input | W | Operand value (ignored for operators) |
| res_req | input | 1 | Pop the top entry to the result port |
| res_valid | output | 1 | One-cycle pulse: `res_data` holds a popped value |
| res_data | output | W | Popped result |
| top_data | output | W | Current top entry (0 when empty) |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |
| underflow_err | output | 1 | Sticky: operator or request lacked entries |
| overflow_err | output | 1 | Sticky: operand pushed into a full stack |

## Verification
Every token, request and clear takes effect at the clock edge that accepts it. `top_data`, `empty`, `full` and both flags therefore change one edge after the stimulus, and `res_valid` with `res_data` appear one edge after the request and drop one edge later. The bench drives on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. It makes one extra sample a cycle later to confirm that the result pulse has ended. `tok_ready` is combinational, so it is sampled shortly after the inputs change and before any rising edge.

// File: rtl/rpn_pkg.sv
package rpn_pkg;

    typedef enum logic [1:0] {
        TK_OPND = 2'b00,
        TK_ADD  = 2'b01,
        TK_SUB  = 2'b10,
        TK_MUL  = 2'b11
    } tok_kind_e;

    typedef enum logic [1:0] {
        SO_HOLD,
        SO_PUSH,
        SO_POP,
        SO_FOLD
    } stk_op_e;

    typedef struct packed {
        stk_op_e op;
        logic    set_ovf;
        logic    set_unf;
        logic    take_res;
    } ctrl_t;

    function automatic logic is_operator(input tok_kind_e k);
        return k != TK_OPND;
    endfunction

endpackage

// File: rtl/rpn_stack.sv
module rpn_stack
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  stk_op_e       op,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  top,
    output logic [W-1:0]  second,
    output logic          has_two,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else begin
            case (op)
                SO_PUSH: cnt <= cnt + CW'(1);
                SO_POP:  cnt <= cnt - CW'(1);
                SO_FOLD: cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (!clr) begin
                if (op == SO_PUSH && cnt == CW'(i))
                    mem[i] <= wdata;
                else if (op == SO_FOLD && cnt == CW'(i + 2))
                    mem[i] <= wdata;
            end
        end
    end

    always_comb begin
        top    = '0;
        second = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == CW'(i + 1)) top    = mem[i];
            if (cnt == CW'(i + 2)) second = mem[i];
        end
    end

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign has_two = (cnt >= CW'(2));

endmodule

// File: rtl/rpn_alu.sv
module rpn_alu
    import rpn_pkg::*;
#(
    parameter int W = 16
) (
    input  tok_kind_e     kind,
    input  logic [W-1:0]  lhs,
    input  logic [W-1:0]  rhs,
    output logic [W-1:0]  res
);
    always_comb begin
        case (kind)
            TK_ADD:  res = lhs + rhs;
            TK_SUB:  res = lhs - rhs;
            TK_MUL:  res = lhs * rhs;
            default: res = rhs;
        endcase
    end
endmodule

// File: rtl/rpn_flags.sv
module rpn_flags (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic set_ovf,
    input  logic set_unf,
    output logic ovf,
    output logic unf
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            ovf <= ovf | set_ovf;
            unf <= unf | set_unf;
        end
    end
endmodule

// File: rtl/rpn_eval.sv
module rpn_eval
    import rpn_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tok_valid,
    output logic          tok_ready,
    input  logic [1:0]    tok_kind,
    input  logic [W-1:0]  tok_value,
    input  logic          res_req,
    output logic          res_valid,
    output logic [W-1:0]  res_data,
    output logic [W-1:0]  top_data,
    output logic          empty,
    output logic          full,
    output logic          underflow_err,
    output logic          overflow_err
);
    tok_kind_e    kind;
    ctrl_t        ctl;
    logic         accept;
    logic         has_two;
    logic [W-1:0] second;
    logic [W-1:0] alu_res;
    logic [W-1:0] wdata;

    assign kind      = tok_kind_e'(tok_kind);
    assign tok_ready = !clr && !res_req;
    assign accept    = tok_valid && tok_ready;

    rpn_alu #(.W(W)) u_alu (
        .kind (kind),
        .lhs  (second),
        .rhs  (top_data),
        .res  (alu_res)
    );

    always_comb begin
        ctl = '{op: SO_HOLD, set_ovf: 1'b0, set_unf: 1'b0, take_res: 1'b0};
        if (!clr) begin
            if (res_req) begin
                if (!empty) begin
                    ctl.op       = SO_POP;
                    ctl.take_res = 1'b1;
                end else begin
                    ctl.set_unf = 1'b1;
                end
            end else if (accept) begin
                if (!is_operator(kind)) begin
                    if (full) ctl.set_ovf = 1'b1;
                    else      ctl.op      = SO_PUSH;
                end else if (has_two) begin
                    ctl.op = SO_FOLD;
                end else begin
                    ctl.set_unf = 1'b1;
                end
            end
        end
    end

    assign wdata = (ctl.op == SO_FOLD) ? alu_res : tok_value;

    rpn_stack #(.W(W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .op      (ctl.op),
        .wdata   (wdata),
        .top     (top_data),
        .second  (second),
        .has_two (has_two),
        .empty   (empty),
        .full    (full)
    );

    rpn_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .set_ovf (ctl.set_ovf),
        .set_unf (ctl.set_unf),
        .ovf     (overflow_err),
        .unf     (underflow_err)
    );

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= ctl.take_res;
            if (ctl.take_res) res_data <= top_data;
        end
    end

endmodule

// File: rtl/rpn_eval_chk.sv
module rpn_eval_chk #(
    parameter int W = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          tok_valid,
    input logic          tok_ready,
    input logic [1:0]    tok_kind,
    input logic [W-1:0]  tok_value,
    input logic          res_req,
    input logic          res_valid,
    input logic [W-1:0]  top_data,
    input logic          empty,
    input logic          full,
    input logic          underflow_err,
    input logic          overflow_err
);
    // R1
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (empty && !full && !underflow_err && !overflow_err && !res_valid));

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_ready && tok_kind == 2'b00 && !full)
        |=> (!empty && top_data == $past(tok_value)));

    // R6
    op_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_ready && tok_kind != 2'b00 && empty)
        |=> (underflow_err && empty));

    // R7
    push_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (tok_valid && tok_ready && tok_kind == 2'b00 && full)
        |=> (overflow_err && full && $stable(top_data)));

    // R8
    empty_full_chk: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    // R9
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(res_req) && !$past(empty) && !$past(clr)));

    // R10
    ready_block_chk: assert property (@(posedge clk) disable iff (rst)
        (clr || res_req) |-> !tok_ready);

    // R11
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow_err && !clr) |=> overflow_err);

    // R11
    sticky_unf_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow_err && !clr) |=> underflow_err);
endmodule

bind rpn_eval rpn_eval_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .clr           (clr),
    .tok_valid     (tok_valid),
    .tok_ready     (tok_ready),
    .tok_kind      (tok_kind),
    .tok_value     (tok_value),
    .res_req       (res_req),
    .res_valid     (res_valid),
    .top_data      (top_data),
    .empty         (empty),
    .full          (full),
    .underflow_err (underflow_err),
    .overflow_err  (overflow_err)
);

// File: tb/rpn_eval_test.sv
module rpn_eval_test;
    localparam int W     = 16;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          tok_valid = 1'b0;
    logic          tok_ready;
    logic [1:0]    tok_kind = 2'b00;
    logic [W-1:0]  tok_value = '0;
    logic          res_req = 1'b0;
    logic          res_valid;
    logic [W-1:0]  res_data;
    logic [W-1:0]  top_data;
    logic          empty, full, underflow_err, overflow_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    rpn_eval #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .clr(clr),
        .tok_valid(tok_valid), .tok_ready(tok_ready),
        .tok_kind(tok_kind), .tok_value(tok_value),
        .res_req(res_req), .res_valid(res_valid), .res_data(res_data),
        .top_data(top_data), .empty(empty), .full(full),
        .underflow_err(underflow_err), .overflow_err(overflow_err)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] v);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = 2'b00; tok_value = v;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic oper(input logic [1:0] k);
        @(negedge clk);
        tok_valid = 1'b1; tok_kind = k; tok_value = 16'hDEAD;
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic request(input string req, input logic exp_vld, input logic [W-1:0] exp_d);
        @(negedge clk);
        res_req = 1'b1;
        @(negedge clk);
        res_req = 1'b0;
        chk(req, W'(res_valid), W'(exp_vld));
        if (exp_vld) chk(req, res_data, exp_d);
        @(negedge clk);
        chk("R9 pulse width", W'(res_valid), '0);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 empty", W'(empty), 16'd1);
        chk("R1 full", W'(full), 16'd0);
        chk("R1 unf", W'(underflow_err), 16'd0);
        chk("R1 ovf", W'(overflow_err), 16'd0);
        chk("R1 res_valid", W'(res_valid), 16'd0);
    endtask

    task automatic t_push_peek();
        push(16'd7);
        chk("R2 top", top_data, 16'd7);
        chk("R2 empty", W'(empty), 16'd0);
    endtask

    task automatic t_lifo();
        do_clear();
        push(16'd10); push(16'd20); push(16'd30);
        request("R3 first", 1'b1, 16'd30);
        request("R3 second", 1'b1, 16'd20);
        request("R3 third", 1'b1, 16'd10);
        chk("R8 empty after pops", W'(empty), 16'd1);
    endtask

    task automatic t_ops();
        do_clear();
        push(16'd5); push(16'd2); oper(2'b10);
        chk("R4 5 2 -", top_data, 16'd3);
        do_clear();
        push(16'd2); push(16'd5); oper(2'b10);
        chk("R4 2 5 -", top_data, 16'hFFFD);
        do_clear();
        push(16'd4); push(16'd2); oper(2'b11);
        chk("R4 4 2 *", top_data, 16'd8);
        push(16'd5); push(16'd2); oper(2'b10); oper(2'b01);
        chk("R4 nested +", top_data, 16'd11);
        request("R4 result", 1'b1, 16'd11);
        chk("R4 stack shrank", W'(empty), 16'd1);
    endtask

    task automatic t_wrap();
        do_clear();
        push(16'd300); push(16'd300); oper(2'b11);
        chk("R5 mul wrap", top_data, 16'd24464);
        push(16'd32767); push(16'd1); oper(2'b01);
        chk("R5 add wrap", top_data, 16'h8000);
    endtask

    task automatic t_underflow();
        do_clear();
        push(16'd9); oper(2'b01);
        chk("R6 flag", W'(underflow_err), 16'd1);
        chk("R6 top kept", top_data, 16'd9);
        push(16'd4); oper(2'b01);
        chk("R11 unf sticky", W'(underflow_err), 16'd1);
        chk("R11 op after flag", top_data, 16'd13);
        do_clear();
        chk("R1 clr drops unf", W'(underflow_err), 16'd0);
        request("R9 empty request", 1'b0, '0);
        chk("R9 empty request flag", W'(underflow_err), 16'd1);
    endtask

    task automatic t_overflow();
        do_clear();
        for (int i = 1; i <= DEPTH; i++) begin
            push(W'(i));
            if (i < DEPTH) chk("R8 not full", W'(full), 16'd0);
        end
        chk("R8 full", W'(full), 16'd1);
        push(16'd99);
        chk("R7 flag", W'(overflow_err), 16'd1);
        chk("R7 dropped", top_data, W'(DEPTH));
        oper(2'b01);
        chk("R11 ovf sticky", W'(overflow_err), 16'd1);
        chk("R8 full after fold", W'(full), 16'd0);
        do_clear();
        chk("R1 clr empty", W'(empty), 16'd1);
        chk("R1 clr ovf", W'(overflow_err), 16'd0);
    endtask

    task automatic t_priority();
        do_clear();
        push(16'd42);
        @(negedge clk);
        res_req = 1'b1; tok_valid = 1'b1; tok_kind = 2'b00; tok_value = 16'd77;
        #1;
        chk("R10 ready low", W'(tok_ready), 16'd0);
        @(negedge clk);
        res_req = 1'b0; tok_valid = 1'b0;
        chk("R10 request wins", res_data, 16'd42);
        chk("R10 token not taken", W'(empty), 16'd1);
        @(negedge clk);
        clr = 1'b1;
        #1;
        chk("R10 ready low on clr", W'(tok_ready), 16'd0);
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_push_peek();
        t_lifo();
        t_ops();
        t_wrap();
        t_underflow();
        t_overflow();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule